// File: doc/BRIEF.md
# Pipelined Tag Store with Equality Match

This block is a single-port, synchronous tag memory with a built-in equality comparator. It is intended to hold address tags for a secondary cache. On every rising clock edge it samples the address, the tag input, two chip selects of opposite polarity, a write strobe and a load strobe for the tag input register. The registered request is carried out in the following cycle. Read data and the compare result each pass through one more register before they reach the outputs.

The tag input register loads only when its load strobe is asserted during a selected cycle. A tag presented for a lookup can therefore stay in the block. If the lookup misses, a later fill cycle writes that held tag into the array, and the tag does not have to be driven again. The output enables for the data and for the match flag are not clocked. Each is modelled as an output qualifier beside its data output, and neither is a tri-state pad.

The control is a small machine that holds the kind of the registered cycle. Its states are IDLE (deselected), READ, CMP (compare), WRITE and FILL. The next state is chosen every edge from the select, write and load strobes, and any state can move to any other state.

Top module: `tagram_top`

## Requirements
- R1: The block is selected only when `ce_n`=0 and `ce`=1. In any other cycle it neither writes the array, nor loads the tag register, nor produces read data, whatever the other strobes are.
- R2: A selected cycle with `we_n`=1 reads the word at the sampled address. The word appears on `dq` at the second rising edge after the inputs are sampled. With `oe_n`=0, `dq_en` is high for exactly that one cycle.
- R3: A selected cycle with `we_n`=1 and `den_n`=0 is a compare. `match` at the second rising edge after sampling is 1 if the newly loaded tag equals the stored word, and 0 if it does not.
- R4: `match` keeps its value through every cycle that is not a compare, including deselected cycles, reads and writes.
- R5: A selected cycle with `we_n`=0 and `den_n`=0 loads `din` into the tag register and stores it at the sampled address.
- R6: A selected cycle with `we_n`=0 and `den_n`=1 is a fill. It stores the value already held in the tag register at the sampled address, and the `din` present in that cycle is ignored.
- R7: The tag register changes only in a selected cycle with `den_n`=0. Otherwise it keeps its last value.
- R8: `dq_en` is low in the cycle that follows a write or a fill, and it is low at any time `oe_n`=1, with no clock needed.
- R9: `match_en` follows the inverse of `moe_n` with no clock. Toggling `moe_n` does not change the value of `match`.
- R10: After reset, `dq_en`=0, `match`=0 and the tag register holds zero, so a fill issued before any tag load stores zero.
- R11: A compare or read issued in the cycle directly after a write to the same address sees the newly written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Word address, sampled on the clock |
| din | input | DATA_W | Tag or write data, sampled on the clock |
| ce_n | input | 1 | Active-low select |
| ce | input | 1 | Active-high select |
| we_n | input | 1 | Active-low write strobe |
| den_n | input | 1 | Active-low tag register load strobe |
| oe_n | input | 1 | Active-low data output enable, not clocked |
| moe_n | input | 1 | Active-low match output enable, not clocked |
| dq | output | DATA_W | Registered read data |
| dq_en | output | 1 | High when `dq` is being driven |
| match | output | 1 | Registered compare result |
| match_en | output | 1 | High when `match` is being driven |

## Verification
The hardest case to reach is a fill that must write a tag loaded several cycles earlier. The check only means something if no tag load slips in between. The stimulus first loads a known tag with a compare. It then issues deselected cycles that hold `den_n` low and drive different `din` values, then fills an unused address, and finally reads that address back through `dq`. Back-to-back write-then-compare and read-then-write sequences are also placed at adjacent edges, so that every pipeline stage is tested at its exact cycle boundary.

// File: rtl/tagram_pkg.sv
package tagram_pkg;
    // Kind of cycle registered at the last clock edge
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_CMP,
        ST_WRITE,
        ST_FILL
    } cyc_e;
endpackage

// File: rtl/tagram_ctrl.sv
module tagram_ctrl
    import tagram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              ce,
    input  logic              we_n,
    input  logic              den_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output cyc_e              cyc_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] din_q
);
    logic sel;
    logic tag_load;
    cyc_e cyc_d;

    assign sel      = !ce_n && ce;
    assign tag_load = sel && !den_n;

    // next-state selection
    always_comb begin
        unique case ({sel, we_n, den_n})
            3'b111:  cyc_d = ST_READ;
            3'b110:  cyc_d = ST_CMP;
            3'b100:  cyc_d = ST_WRITE;
            3'b101:  cyc_d = ST_FILL;
            default: cyc_d = ST_IDLE;
        endcase
    end

    // state and input registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q  <= ST_IDLE;
            addr_q <= '0;
            din_q  <= '0;
        end else begin
            cyc_q  <= cyc_d;
            addr_q <= addr;
            if (tag_load)
                din_q <= din;
        end
    end

    // R7
    tag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ce_n && ce && !den_n) |=> $stable(din_q));

    // R1
    desel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ce_n && ce) |=> (cyc_q == ST_IDLE));
endmodule

// File: rtl/tagram_array.sv
module tagram_array
    import tagram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cyc_e              cyc,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [DATA_W-1:0] din_q,
    output logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] rdata_q,
    output logic              rd_vld_q
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    assign rd_word = mem[addr_q];

    // array write: a write or fill stores the tag register
    always_ff @(posedge clk) begin
        if (cyc == ST_WRITE || cyc == ST_FILL)
            mem[addr_q] <= din_q;
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rd_vld_q <= 1'b0;
        end else begin
            unique case (cyc)
                ST_READ, ST_CMP: begin
                    rdata_q  <= rd_word;
                    rd_vld_q <= 1'b1;
                end
                default: begin
                    rd_vld_q <= 1'b0;
                end
            endcase
        end
    end

    // R5
    store_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == ST_WRITE || cyc == ST_FILL) |=> (mem[$past(addr_q)] == $past(din_q)));

    // R8
    wr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == ST_WRITE || cyc == ST_FILL) |=> !rd_vld_q);
endmodule

// File: rtl/tagram_match.sv
module tagram_match
    import tagram_pkg::*;
#(
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cyc_e              cyc,
    input  logic [DATA_W-1:0] din_q,
    input  logic [DATA_W-1:0] rd_word,
    output logic              match_q
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            match_q <= 1'b0;
        else if (cyc == ST_CMP)
            match_q <= (din_q == rd_word);
    end

    // R4
    match_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc != ST_CMP) |=> $stable(match_q));
endmodule

// File: rtl/tagram_top.sv
module tagram_top
    import tagram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              ce_n,
    input  logic              ce,
    input  logic              we_n,
    input  logic              den_n,
    input  logic              oe_n,
    input  logic              moe_n,
    output logic [DATA_W-1:0] dq,
    output logic              dq_en,
    output logic              match,
    output logic              match_en
);
    cyc_e              cyc_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] din_q;
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] rdata_q;
    logic              rd_vld_q;
    logic              match_q;

    tagram_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_ctrl (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .ce(ce), .we_n(we_n),
        .den_n(den_n), .addr(addr), .din(din),
        .cyc_q(cyc_q), .addr_q(addr_q), .din_q(din_q)
    );

    tagram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_array (
        .clk(clk), .rst_n(rst_n), .cyc(cyc_q), .addr_q(addr_q),
        .din_q(din_q), .rd_word(rd_word), .rdata_q(rdata_q),
        .rd_vld_q(rd_vld_q)
    );

    tagram_match #(.DATA_W(DATA_W)) i_match (
        .clk(clk), .rst_n(rst_n), .cyc(cyc_q), .din_q(din_q),
        .rd_word(rd_word), .match_q(match_q)
    );

    // output gating: enables act without a clock
    always_comb begin
        dq       = rdata_q;
        dq_en    = rd_vld_q && !oe_n;
        match    = match_q;
        match_en = !moe_n;
    end

    // R3
    cmp_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q == ST_CMP) |=> (match_q == ($past(din_q) == $past(rd_word))));
endmodule

// File: tb/test_tagram_top.sv
`timescale 1ns/100ps
module test_tagram_top;
    localparam int AW = 10;
    localparam int DW = 18;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] din;
    logic          ce_n, ce, we_n, den_n, oe_n, moe_n;
    logic [DW-1:0] dq;
    logic          dq_en, match, match_en;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    tagram_top #(.ADDR_W(AW), .DATA_W(DW)) i_tagram_top (
        .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .ce_n(ce_n),
        .ce(ce), .we_n(we_n), .den_n(den_n), .oe_n(oe_n), .moe_n(moe_n),
        .dq(dq), .dq_en(dq_en), .match(match), .match_en(match_en)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // apply one cycle of inputs, wait to the next falling edge
    task automatic cyc(input logic cn, input logic c, input logic w,
                       input logic d, input logic [AW-1:0] a,
                       input logic [DW-1:0] v);
        ce_n = cn; ce = c; we_n = w; den_n = d; addr = a; din = v;
        @(negedge clk);
    endtask

    task automatic do_idle();                         cyc(1, 0, 1, 1, '0, '0); endtask
    task automatic do_read(input logic [AW-1:0] a);   cyc(0, 1, 1, 1, a, '0);  endtask
    task automatic do_cmp(input logic [AW-1:0] a, input logic [DW-1:0] v);
        cyc(0, 1, 1, 0, a, v);
    endtask
    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] v);
        cyc(0, 1, 0, 0, a, v);
    endtask
    task automatic do_fill(input logic [AW-1:0] a, input logic [DW-1:0] junk);
        cyc(0, 1, 0, 1, a, junk);
    endtask

    task automatic t_reset();
        rst_n = 0; oe_n = 0; moe_n = 0;
        ce_n = 1; ce = 0; we_n = 1; den_n = 1; addr = '0; din = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk(dq_en == 0, "R10", dq_en, 0);
        chk(match == 0, "R10", match, 0);
        do_fill(10'd6, 18'h3ffff);   // tag register still zero
        do_idle();
        do_read(10'd6);
        do_idle();
        chk(dq == 0, "R10", dq, 0);
    endtask

    task automatic t_write_read();
        do_write(10'd1, 18'h12345);
        do_write(10'd2, 18'h2abcd);
        do_read(10'd1);
        do_read(10'd2);
        chk(dq == 18'h12345 && dq_en, "R2", dq, 18'h12345);
        do_idle();
        chk(dq == 18'h2abcd && dq_en, "R5", dq, 18'h2abcd);
        do_idle();
        chk(dq_en == 0, "R2", dq_en, 0);
    endtask

    task automatic t_compare();
        do_cmp(10'd1, 18'h12345);
        do_idle();
        chk(match == 1, "R3", match, 1);
        do_cmp(10'd2, 18'h00001);
        do_idle();
        chk(match == 0, "R3", match, 0);
    endtask

    task automatic t_hold();
        do_cmp(10'd1, 18'h12345);
        do_idle(); do_idle();
        do_read(10'd2);
        do_write(10'd7, 18'h00777);
        do_idle(); do_idle();
        chk(match == 1, "R4", match, 1);
    endtask

    task automatic t_fill();
        do_cmp(10'd3, 18'h1beef);          // miss on an empty slot
        do_fill(10'd3, 18'h00bad);         // installs the held tag
        do_idle();
        do_read(10'd3);
        do_idle();
        chk(dq == 18'h1beef, "R6", dq, 18'h1beef);
        do_cmp(10'd3, 18'h1beef);
        do_idle();
        chk(match == 1, "R6", match, 1);
    endtask

    task automatic t_no_load();
        do_cmp(10'd1, 18'h12345);          // tag register = 12345
        cyc(1, 1, 1, 0, 10'd1, 18'h0f0f0); // deselected, load strobe low
        cyc(0, 0, 0, 0, 10'd1, 18'h0a0a0); // deselected write attempt
        do_fill(10'd4, 18'h3ffff);
        do_idle();
        do_read(10'd4);
        do_idle();
        chk(dq == 18'h12345, "R7", dq, 18'h12345);
        do_read(10'd1);
        do_idle();
        chk(dq == 18'h12345, "R1", dq, 18'h12345);
    endtask

    task automatic t_oe();
        do_read(10'd2);
        do_write(10'd8, 18'h00088);
        chk(dq_en == 1, "R2", dq_en, 1);
        oe_n = 1; #1;
        chk(dq_en == 0, "R8", dq_en, 0);
        oe_n = 0; #1;
        do_idle();
        chk(dq_en == 0, "R8", dq_en, 0);
    endtask

    task automatic t_moe();
        do_cmp(10'd2, 18'h2abcd);
        do_idle();
        moe_n = 1; #1;
        chk(match_en == 0, "R9", match_en, 0);
        chk(match == 1, "R9", match, 1);
        moe_n = 0; #1;
        chk(match_en == 1, "R9", match_en, 1);
    endtask

    task automatic t_order();
        do_write(10'd5, 18'h05555);
        do_cmp(10'd5, 18'h05555);
        do_read(10'd5);
        chk(match == 1, "R11", match, 1);
        do_idle();
        chk(dq == 18'h05555, "R11", dq, 18'h05555);
    endtask

    initial begin
        t_reset();
        t_write_read();
        t_compare();
        t_hold();
        t_fill();
        t_no_load();
        t_oe();
        t_moe();
        t_order();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule